// File: doc/BRIEF.md
# Dual-Clock Field Store

This block is a line or field buffer with two fully independent ports, each on its own clock. A writer fills the array through a one-word input staging register, and a reader drains it through a prefetched output register. Each side keeps its own address pointer. The pointers step forward and wrap at the configured depth. No full or empty status is kept, so a fast writer may overrun a slow reader and the reverse.

Each port has an active-low enable and an active-low synchronous pointer reset. A pointer reset that arrives while its port is disabled is held. It is carried out on the next enabled edge of that port. A write reset first pushes any staged word into the array. A read reset reloads the output prefetch register from address 0. The read side also has an active-low output enable. When that enable is off, the data output is forced to zero and a drive-enable output is lowered. Each clock domain also has its own asynchronous reset, which clears that side's pointer, valid bits, pending reset and output registers.

Top module: `dual_clock_field_store`

## Requirements
- R1: On a write-clock edge with `wr_en_n` low and no reset request, `wr_data` is captured into staging and the write pointer advances by one, wrapping from DEPTH-1 to 0. With `wr_en_n` high, the pointer holds and `wr_data` is never stored.
- R2: A staged word reaches the array only at the next enabled write edge or at a write reset. Until then a reader sees the previous contents of that address.
- R3: A write edge with `wr_en_n` low and `wr_rst_n` low commits any staged word and sets the write pointer to 0. It captures nothing on that edge.
- R4: `wr_rst_n` low on a write edge with `wr_en_n` high is remembered. It is executed, exactly as in R3, on the next edge with `wr_en_n` low, and that edge captures nothing.
- R5: On a read-clock edge with `rd_en_n` low and no reset request, the word at the read pointer appears in the output register and the pointer advances by one. The pointer wraps from DEPTH-1 to 0.
- R6: On a read edge with `rd_en_n` high, the read pointer and the output register both hold.
- R7: A read edge with `rd_en_n` low and `rd_rst_n` low sets the read pointer to 0 and prefetches address 0. The output register is unchanged on that edge, and the next enabled read presents the word at address 0.
- R8: `rd_rst_n` low on a read edge with `rd_en_n` high is remembered. It is executed, as in R7, on the next edge with `rd_en_n` low.
- R9: `rd_oe_n` is sampled on each read edge. After a high sample, `rd_data` is all zeros and `rd_out_en` is 0. After a low sample, `rd_out_en` is 1 and `rd_data` shows the output register.
- R10: The asynchronous reset of a side clears that side's pointer, buffer valid bits and pending reset at once. On the read side it also sets `rd_data` to 0 and `rd_out_en` to 0. The first read after release, with no read reset, presents address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_arst_n | input | 1 | Asynchronous reset of the write side, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Synchronous write-pointer reset, active low |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_arst_n | input | 1 | Asynchronous reset of the read side, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Synchronous read-pointer reset, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_data | output | WIDTH | Presented word, zero while the output is disabled |
| rd_out_en | output | 1 | High while the output is driven |

## Verification
The bench builds the block with DEPTH=16 and WIDTH=8. With these values a 16-word ramp fills the whole array, and a 17-read sweep crosses the wrap point of the read pointer. Reading the last ramp word back shows whether the flush on write reset happened. The two clocks run at unrelated periods. The stimulus is ordered so that every commit in the write domain lands before the read that depends on it. That lets the bench tell apart a word still in staging (old contents visible) from a word already committed.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [1:0] {
    PORT_HOLD   = 2'd0,
    PORT_STEP   = 2'd1,
    PORT_REZERO = 2'd2
  } port_act_e;

  // Next pointer value in a ring of 'depth' entries.
  function automatic logic [31:0] wrap_inc(input logic [31:0] p, input logic [31:0] depth);
    return (p == depth - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

  // Per-edge action of a port: disabled holds, a live or remembered reset wins over a step.
  function automatic port_act_e decode_act(input logic en_n, input logic rst_n, input logic pend);
    if (en_n)               return PORT_HOLD;
    else if (!rst_n || pend) return PORT_REZERO;
    else                    return PORT_STEP;
  endfunction

endpackage

// File: rtl/fs_ram.sv
module fs_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr [NRD],
  output logic [WIDTH-1:0] rdata [NRD]
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rport
    assign rdata[g] = cells[raddr[g]];
  end

endmodule

// File: rtl/fs_wr_port.sv
module fs_wr_port #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_arst_n,
  input  logic             wr_en_n,
  input  logic             wr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [WIDTH-1:0] mem_wdata
);
  import fs_pkg::*;

  logic [AW-1:0]    wptr;
  logic [AW-1:0]    stage_addr;
  logic [WIDTH-1:0] stage_data;
  logic             stage_vld;
  logic             rst_pend;

  // named events for the checks below
  port_act_e        wr_act;
  logic [AW-1:0]    wptr_next;
  logic             ev_defer;

  assign wr_act    = decode_act(wr_en_n, wr_rst_n, rst_pend);
  assign wptr_next = AW'(wrap_inc(32'(wptr), 32'(DEPTH)));
  assign ev_defer  = wr_en_n && !wr_rst_n;

  // any enabled edge (step or reset) empties staging into the array
  assign mem_we    = wr_arst_n && (wr_act != PORT_HOLD) && stage_vld;
  assign mem_waddr = stage_addr;
  assign mem_wdata = stage_data;

  always_ff @(posedge wr_clk or negedge wr_arst_n) begin
    if (!wr_arst_n) begin
      wptr       <= '0;
      stage_addr <= '0;
      stage_data <= '0;
      stage_vld  <= 1'b0;
      rst_pend   <= 1'b0;
    end else begin
      unique case (wr_act)
        PORT_REZERO: begin
          wptr      <= '0;
          stage_vld <= 1'b0;
          rst_pend  <= 1'b0;
        end
        PORT_STEP: begin
          stage_data <= wr_data;
          stage_addr <= wptr;
          stage_vld  <= 1'b1;
          wptr       <= wptr_next;
        end
        default: begin
          if (ev_defer) rst_pend <= 1'b1;
        end
      endcase
    end
  end

  assert_wr_hold_R1: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (wr_act == PORT_HOLD) |=> $stable(wptr));

  assert_wr_step_R1: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (wr_act == PORT_STEP) |=> (wptr == AW'(wrap_inc(32'($past(wptr)), 32'(DEPTH)))));

  assert_wr_stage_R2: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (wr_act == PORT_STEP) |=> (stage_vld && stage_addr == $past(wptr)));

  assert_wr_rezero_R3: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    (wr_act == PORT_REZERO) |=> (wptr == '0 && !stage_vld && !rst_pend));

  assert_wr_defer_R4: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
    ev_defer |=> rst_pend);

endmodule

// File: rtl/fs_rd_port.sv
module fs_rd_port #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             rd_clk,
  input  logic             rd_arst_n,
  input  logic             rd_en_n,
  input  logic             rd_rst_n,
  input  logic             rd_oe_n,
  input  logic [WIDTH-1:0] mem_rdata_cur,
  input  logic [WIDTH-1:0] mem_rdata_nxt,
  output logic [AW-1:0]    mem_raddr_cur,
  output logic [AW-1:0]    mem_raddr_nxt,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_out_en
);
  import fs_pkg::*;

  logic [AW-1:0]    rptr;
  logic [WIDTH-1:0] pf_data;
  logic             pf_vld;
  logic             rst_pend;
  logic [WIDTH-1:0] out_q;
  logic             oe_q;

  port_act_e        rd_act;
  logic [AW-1:0]    rptr_next;
  logic             ev_defer;
  logic [WIDTH-1:0] present_word;

  assign rd_act        = decode_act(rd_en_n, rd_rst_n, rst_pend);
  assign rptr_next     = AW'(wrap_inc(32'(rptr), 32'(DEPTH)));
  assign ev_defer      = rd_en_n && !rd_rst_n;
  assign mem_raddr_cur = rptr;
  assign mem_raddr_nxt = (rd_act == PORT_REZERO) ? '0 : rptr_next;
  // after an async reset the prefetch is empty, so go to the array directly
  assign present_word  = pf_vld ? pf_data : mem_rdata_cur;

  always_ff @(posedge rd_clk or negedge rd_arst_n) begin
    if (!rd_arst_n) begin
      rptr     <= '0;
      pf_data  <= '0;
      pf_vld   <= 1'b0;
      rst_pend <= 1'b0;
      out_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= !rd_oe_n;
      unique case (rd_act)
        PORT_REZERO: begin
          rptr     <= '0;
          pf_data  <= mem_rdata_nxt;
          pf_vld   <= 1'b1;
          rst_pend <= 1'b0;
        end
        PORT_STEP: begin
          out_q   <= present_word;
          rptr    <= rptr_next;
          pf_data <= mem_rdata_nxt;
          pf_vld  <= 1'b1;
        end
        default: begin
          if (ev_defer) rst_pend <= 1'b1;
        end
      endcase
    end
  end

  assign rd_data   = oe_q ? out_q : '0;
  assign rd_out_en = oe_q;

  assert_rd_step_R5: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (rd_act == PORT_STEP) |=> (rptr == AW'(wrap_inc(32'($past(rptr)), 32'(DEPTH)))));

  assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (rd_act == PORT_HOLD) |=> ($stable(rptr) && $stable(out_q)));

  assert_rd_rezero_R7: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    (rd_act == PORT_REZERO) |=> (rptr == '0 && pf_vld && $stable(out_q)));

  assert_rd_defer_R8: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    ev_defer |=> rst_pend);

  assert_rd_off_R9: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
    rd_oe_n |=> (rd_data == '0 && !rd_out_en));

endmodule

// File: rtl/dual_clock_field_store.sv
module dual_clock_field_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8
) (
  input  logic             wr_clk,
  input  logic             wr_arst_n,
  input  logic             wr_en_n,
  input  logic             wr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_arst_n,
  input  logic             rd_en_n,
  input  logic             rd_rst_n,
  input  logic             rd_oe_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_out_en
);
  localparam int AW  = $clog2(DEPTH);
  localparam int NRD = 2;

  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [WIDTH-1:0] mem_wdata;
  logic [AW-1:0]    mem_raddr [NRD];
  logic [WIDTH-1:0] mem_rdata [NRD];

  fs_wr_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
    .wr_clk    (wr_clk),
    .wr_arst_n (wr_arst_n),
    .wr_en_n   (wr_en_n),
    .wr_rst_n  (wr_rst_n),
    .wr_data   (wr_data),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  fs_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_ram (
    .wr_clk (wr_clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .raddr  (mem_raddr),
    .rdata  (mem_rdata)
  );

  fs_rd_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
    .rd_clk        (rd_clk),
    .rd_arst_n     (rd_arst_n),
    .rd_en_n       (rd_en_n),
    .rd_rst_n      (rd_rst_n),
    .rd_oe_n       (rd_oe_n),
    .mem_rdata_cur (mem_rdata[0]),
    .mem_rdata_nxt (mem_rdata[1]),
    .mem_raddr_cur (mem_raddr[0]),
    .mem_raddr_nxt (mem_raddr[1]),
    .rd_data       (rd_data),
    .rd_out_en     (rd_out_en)
  );

endmodule

// File: tb/test_dual_clock_field_store.sv
module test_dual_clock_field_store;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  // row: [7] rd_en_n [6] rd_rst_n [5] rd_oe_n [4] expected rd_out_en [3:0] ramp index expected
  localparam logic [7:0] RD_TBL [11] = '{
    8'b0_1_0_1_0000,  // R5 read word 0
    8'b0_1_0_1_0001,  // R5 read word 1
    8'b1_1_0_1_0001,  // R6 disabled, hold
    8'b0_1_0_1_0010,  // R5 word 2
    8'b0_1_1_0_0011,  // R9 output off (word 3 consumed)
    8'b1_1_0_1_0011,  // R9 back on, word 3 visible
    8'b1_0_0_1_0011,  // R8 reset while disabled: remembered
    8'b1_1_0_1_0011,  // R8 still pending
    8'b0_1_0_1_0011,  // R8 executes, output register unchanged
    8'b0_1_0_1_0000,  // R8 word 0 after deferred reset
    8'b0_1_0_1_0001   // R5 word 1
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_arst_n = 1'b0, rd_arst_n = 1'b0;
  logic wr_en_n = 1'b1, wr_rst_n = 1'b1;
  logic [WIDTH-1:0] wr_data = '0;
  logic rd_en_n = 1'b1, rd_rst_n = 1'b1, rd_oe_n = 1'b1;
  logic [WIDTH-1:0] rd_data;
  logic rd_out_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dual_clock_field_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_dual_clock_field_store (
    .wr_clk(wr_clk), .wr_arst_n(wr_arst_n), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_arst_n(rd_arst_n), .rd_en_n(rd_en_n),
    .rd_rst_n(rd_rst_n), .rd_oe_n(rd_oe_n), .rd_data(rd_data), .rd_out_en(rd_out_en)
  );

  function automatic logic [WIDTH-1:0] ramp(input int i);
    return WIDTH'(i * 7 + 3);
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] exp_d, input logic exp_oe);
    checks++;
    if (rd_data !== exp_d || rd_out_en !== exp_oe) begin
      errors++;
      $display("FAIL %s: rd_data=%h rd_out_en=%b expected rd_data=%h rd_out_en=%b",
               req, rd_data, rd_out_en, exp_d, exp_oe);
    end
  endtask

  task automatic wr_step(input logic en_n, input logic rst_n, input logic [WIDTH-1:0] d);
    @(negedge wr_clk);
    wr_en_n = en_n; wr_rst_n = rst_n; wr_data = d;
    @(posedge wr_clk);
    #1;
    wr_en_n = 1'b1; wr_rst_n = 1'b1;
  endtask

  task automatic rd_step(input logic en_n, input logic rst_n, input logic oe_n);
    @(negedge rd_clk);
    rd_en_n = en_n; rd_rst_n = rst_n; rd_oe_n = oe_n;
    @(posedge rd_clk);
    #1;
    rd_en_n = 1'b1; rd_rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge rd_clk);
    #1;
    check("R10 reset state", '0, 1'b0);
    @(negedge wr_clk); wr_arst_n = 1'b1;
    @(negedge rd_clk); rd_arst_n = 1'b1;

    // ramp into every address, then a live write reset flushes the last word (R1, R3)
    for (int i = 0; i < DEPTH; i++) wr_step(1'b0, 1'b1, ramp(i));
    wr_step(1'b0, 1'b0, 8'hFF);

    rd_step(1'b0, 1'b0, 1'b0);
    check("R7 read reset leaves output register", '0, 1'b1);

    for (int r = 0; r < 11; r++) begin
      logic [7:0] row;
      row = RD_TBL[r];
      rd_step(row[7], row[6], row[5]);
      check($sformatf("R5/R6/R8/R9 table row %0d", r),
            row[4] ? ramp(int'(row[3:0])) : '0, row[4]);
    end

    // full sweep across the wrap point; word 15 only exists if the flush happened
    rd_step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i <= DEPTH; i++) begin
      rd_step(1'b0, 1'b1, 1'b0);
      check($sformatf("R5 wrap / R3 flush, read %0d", i), ramp(i % DEPTH), 1'b1);
    end

    // write side: hold, staging, deferred reset
    wr_step(1'b0, 1'b0, 8'h00);
    wr_step(1'b0, 1'b1, 8'h5A);            // staged at addr 0
    for (int k = 0; k < 3; k++) wr_step(1'b1, 1'b1, 8'hEE);  // R1 ignored
    wr_step(1'b0, 1'b1, 8'h6B);            // commits 5A, stages 6B at addr 1
    wr_step(1'b1, 1'b0, 8'hEE);            // R4 remembered
    wr_step(1'b1, 1'b1, 8'hEE);
    wr_step(1'b0, 1'b1, 8'h7C);            // R4 executes: flush 6B, no capture
    wr_step(1'b0, 1'b1, 8'h8D);            // staged at addr 0

    rd_step(1'b0, 1'b0, 1'b0);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R2 staged word not yet visible", 8'h5A, 1'b1);

    wr_step(1'b0, 1'b0, 8'h00);            // R3 flush of 8D
    rd_step(1'b0, 1'b0, 1'b0);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R2/R3 flushed word at address 0", 8'h8D, 1'b1);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R1 disabled data not stored", 8'h6B, 1'b1);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R4 deferred reset edge captures nothing", ramp(2), 1'b1);

    // read-side asynchronous reset
    @(negedge rd_clk); rd_arst_n = 1'b0;
    #1;
    check("R10 read async reset clears output", '0, 1'b0);
    @(negedge rd_clk); rd_arst_n = 1'b1;
    rd_step(1'b0, 1'b1, 1'b0);
    check("R10 first read after async reset is address 0", 8'h8D, 1'b1);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R10 second read after async reset", 8'h6B, 1'b1);

    // write-side asynchronous reset drops staging and zeroes the pointer
    wr_step(1'b0, 1'b1, 8'h9E);
    @(negedge wr_clk); wr_arst_n = 1'b0;
    @(negedge wr_clk); wr_arst_n = 1'b1;
    wr_step(1'b0, 1'b1, 8'h1F);
    wr_step(1'b0, 1'b0, 8'h00);
    rd_step(1'b0, 1'b0, 1'b0);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R10 write pointer restarts at 0", 8'h1F, 1'b1);
    rd_step(1'b0, 1'b1, 1'b0);
    check("R10 address 1 untouched", 8'h6B, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule